// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers a bank of interrupt request lines (32 by default) and turns each into a latched pending bit. Per source, a polarity bit can invert the input and a trigger bit selects between edge and level detection. A pending source that is enabled is sent to one of two active-high outputs, `irq_o` or `fiq_o`, as its route bit selects. Each output also has its own global unmask bit.

Among the enabled sources routed to `irq_o`, a combinational arbiter finds the winner from a table of per-source priorities, where a lower value means more urgent. The winner is registered into a vector-number word. Software reads that word to learn which source to service. Bit 31 of the word flags that no source is waiting. When the auto-acknowledge control bit is set, that same read also clears the edge-latched pending bit of the source it returned. Input synchronisation belongs to the logic in front of this block.

Top module: `vpic_top`

## Requirements
- R1: After reset, enable, route, polarity, trigger, auto-acknowledge and global mask are all zero, both outputs are low, the vector word (0x1C) reads 0x8000_0000, and priority entry i resets to the value i, so word 0x20 reads 0x0302_0100.
- R2: A polarity bit (register 0x08) of 1 makes that source active when its input is low. A bit of 0 makes it active when its input is high.
- R3: With its trigger bit (register 0x0C) at 0, a source latches pending on the rising edge of its conditioned input. It stays pending after the input falls, until 1 is written to its bit of register 0x10. Reading 0x10 returns the pending bits.
- R4: With its trigger bit at 1, a source is pending exactly while its conditioned input is active, delayed by one register stage. Writing 1 to its bit of 0x10 has no effect on it.
- R5: A pending, enabled source whose route bit (register 0x04) is 1 drives `irq_o`. If the route bit is 0, it drives `fiq_o`.
- R6: The enable register (0x00) gates each source. A disabled source drives neither output and cannot win the vector, but its pending bit is still latched.
- R7: Global mask register 0x18: bit 0 unmasks `fiq_o` and bit 1 unmasks `irq_o`. An output whose bit is 0 stays low.
- R8: Among enabled, IRQ-routed, pending sources, the one with the smallest priority value wins. When values are equal, the lower source index wins.
- R9: The vector word holds the winner index in bits 4:0 and 0 in bit 31, or 0x8000_0000 when no source competes. It is registered one cycle after the pending state it reflects.
- R10: When bit 31 of register 0x14 is 1, a read of the vector word that returns a valid index clears that source's edge-latched pending bit.
- R11: When bit 31 of register 0x14 is 0, reading the vector word leaves pending state unchanged.
- R12: Priorities occupy words 0x20 to 0x3C. Entry i sits in word 0x20 + 4*(i/4), bits 8*(i%4)+4 down to 8*(i%4). The upper three bits of each byte read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request lines, already synchronous |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt request, active high |
| fiq_o | output | 1 | Fast interrupt request, active high |

## Verification
The bench builds the controller with its defaults: 32 sources, 5-bit priorities, a 7-bit address and a 32-bit data word. That makes the full priority table reachable, including entries in the last word and the tie between two equal values held in different words. It also reaches index 25 for read-to-clear and both polarities on sources in either trigger mode.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 7'h00;
    localparam logic [ADDR_W-1:0] ADR_ROUTE  = 7'h04;
    localparam logic [ADDR_W-1:0] ADR_POL    = 7'h08;
    localparam logic [ADDR_W-1:0] ADR_TRIG   = 7'h0C;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 7'h10;
    localparam logic [ADDR_W-1:0] ADR_VCTRL  = 7'h14;
    localparam logic [ADDR_W-1:0] ADR_GMASK  = 7'h18;
    localparam logic [ADDR_W-1:0] ADR_VECT   = 7'h1C;
    // priority words occupy 0x20..0x3C: address bits 6:5 equal 2'b01
    localparam logic [1:0]        PRIO_REGION = 2'b01;

    localparam int VEC_INVALID_BIT = 31;
    localparam int LANE_W          = 8;
endpackage

// File: rtl/vpic_src_cond.sv
module vpic_src_cond #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] clr,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic active;
        logic active_q;
        logic edge_pend_q;

        assign active = src_i[s] ^ pol[s];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active_q    <= 1'b0;
                edge_pend_q <= 1'b0;
            end else begin
                active_q <= active;
                // a new rising edge wins over a clear in the same cycle
                if (active && !active_q)
                    edge_pend_q <= 1'b1;
                else if (clr[s] || ack[s])
                    edge_pend_q <= 1'b0;
            end
        end

        assign pend[s] = trig[s] ? active_q : edge_pend_q;
    end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 5,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        found   = 1'b0;
        best    = '1;
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
                found   = 1'b1;
                best    = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 5,
    parameter int DATA_W  = 32,
    localparam int PRIO_WORDS = (NUM_SRC + 3) / 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_en,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [DATA_W-1:0]         vec_word,
    output logic [NUM_SRC-1:0]        enable_q,
    output logic [NUM_SRC-1:0]        route_q,
    output logic [NUM_SRC-1:0]        pol_q,
    output logic [NUM_SRC-1:0]        trig_q,
    output logic                      vctrl_q,
    output logic [1:0]                gmask_q,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic [NUM_SRC-1:0]        clr_pulse,
    output logic                      vec_read
);
    logic wr, rd, prio_hit;
    logic [2:0] word_sel;
    logic [DATA_W-1:0] rd_mux;

    assign wr       = bus_en && bus_we;
    assign rd       = bus_en && !bus_we;
    assign prio_hit = (bus_addr[6:5] == PRIO_REGION) && (bus_addr[1:0] == 2'b00);
    assign word_sel = bus_addr[4:2];

    assign clr_pulse = (wr && bus_addr == ADR_CLEAR) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign vec_read  = rd && (bus_addr == ADR_VECT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            route_q  <= '0;
            pol_q    <= '0;
            trig_q   <= '0;
            vctrl_q  <= 1'b0;
            gmask_q  <= 2'b00;
        end else if (wr) begin
            case (bus_addr)
                ADR_ENABLE: enable_q <= bus_wdata[NUM_SRC-1:0];
                ADR_ROUTE:  route_q  <= bus_wdata[NUM_SRC-1:0];
                ADR_POL:    pol_q    <= bus_wdata[NUM_SRC-1:0];
                ADR_TRIG:   trig_q   <= bus_wdata[NUM_SRC-1:0];
                ADR_VCTRL:  vctrl_q  <= bus_wdata[VEC_INVALID_BIT];
                ADR_GMASK:  gmask_q  <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    // one priority entry per source, byte lane chosen by index
    for (genvar e = 0; e < NUM_SRC; e++) begin : g_prio
        localparam int WORD = e / 4;
        localparam int LANE = e % 4;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_flat[e*PRIO_W +: PRIO_W] <= PRIO_W'(e);
            else if (wr && prio_hit && word_sel == 3'(WORD))
                prio_flat[e*PRIO_W +: PRIO_W] <= bus_wdata[LANE*LANE_W +: PRIO_W];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (prio_hit) begin
            for (int j = 0; j < 4; j++) begin
                if (int'(word_sel) < PRIO_WORDS && int'(word_sel) * 4 + j < NUM_SRC)
                    rd_mux[j*LANE_W +: PRIO_W] = prio_flat[(int'(word_sel)*4 + j)*PRIO_W +: PRIO_W];
            end
        end else begin
            case (bus_addr)
                ADR_ENABLE: rd_mux[NUM_SRC-1:0] = enable_q;
                ADR_ROUTE:  rd_mux[NUM_SRC-1:0] = route_q;
                ADR_POL:    rd_mux[NUM_SRC-1:0] = pol_q;
                ADR_TRIG:   rd_mux[NUM_SRC-1:0] = trig_q;
                ADR_CLEAR:  rd_mux[NUM_SRC-1:0] = pend;
                ADR_VCTRL:  rd_mux[VEC_INVALID_BIT] = vctrl_q;
                ADR_GMASK:  rd_mux[1:0] = gmask_q;
                ADR_VECT:   rd_mux = vec_word;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 5,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    logic [NUM_SRC-1:0]        enable_q, route_q, pol_q, trig_q;
    logic [NUM_SRC-1:0]        pend, clr_pulse, ack, irq_cand, fiq_cand;
    logic                      vctrl_q, vec_read, win_found;
    logic [1:0]                gmask_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [IDX_W-1:0]          win_idx, vec_idx_q;
    logic                      vec_inv_q;
    logic [DATA_W-1:0]         vec_word;

    vpic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .vec_word(vec_word),
        .enable_q(enable_q), .route_q(route_q), .pol_q(pol_q), .trig_q(trig_q),
        .vctrl_q(vctrl_q), .gmask_q(gmask_q), .prio_flat(prio_flat),
        .clr_pulse(clr_pulse), .vec_read(vec_read)
    );

    vpic_src_cond #(.NUM_SRC(NUM_SRC)) cond_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .pol(pol_q), .trig(trig_q), .clr(clr_pulse), .ack(ack), .pend(pend)
    );

    assign irq_cand = pend & enable_q & route_q;
    assign fiq_cand = pend & enable_q & ~route_q;

    vpic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
        .cand(irq_cand), .prio_flat(prio_flat),
        .found(win_found), .win_idx(win_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_inv_q <= 1'b1;
            vec_idx_q <= '0;
        end else begin
            vec_inv_q <= !win_found;
            vec_idx_q <= win_idx;
        end
    end

    always_comb begin
        vec_word = '0;
        vec_word[VEC_INVALID_BIT] = vec_inv_q;
        vec_word[IDX_W-1:0] = vec_idx_q;
    end

    // read-to-clear of the index that the read returns
    always_comb begin
        ack = '0;
        if (vec_read && vctrl_q && !vec_inv_q)
            ack[vec_idx_q] = 1'b1;
    end

    assign irq_o = gmask_q[1] && (|irq_cand);
    assign fiq_o = gmask_q[0] && (|fiq_cand);
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC-1:0] pol_q,
    input logic [NUM_SRC-1:0] trig_q,
    input logic [1:0]         gmask_q,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] irq_cand,
    input logic               vec_inv_q,
    input logic [IDX_W-1:0]   vec_idx_q
);
    // R4: level sources mirror the previous cycle's conditioned input
    a_r4_level_mirrors_input: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trig_q) == trig_q && $past(pol_q) == pol_q)
        |-> (((pend ^ ($past(src_i) ^ pol_q)) & trig_q) == '0));

    // R5: irq needs an enabled pending source routed to it
    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & enable_q & route_q) != '0));

    // R6: nothing enabled, nothing asserted
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (!irq_o && !fiq_o));

    // R7: global mask bits hold their outputs low
    a_r7_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !gmask_q[0] |-> !fiq_o);
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !gmask_q[1] |-> !irq_o);

    // R9: a valid vector names a source that competed one cycle earlier
    a_r9_vec_was_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_inv_q |-> ((($past(irq_cand) >> vec_idx_q) & 1) != 0));
    a_r9_invalid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_inv_q |-> ($past(irq_cand) == '0));
endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o),
    .enable_q(enable_q), .route_q(route_q), .pol_q(pol_q), .trig_q(trig_q),
    .gmask_q(gmask_q), .pend(pend), .irq_cand(irq_cand),
    .vec_inv_q(vec_inv_q), .vec_idx_q(vec_idx_q)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
    localparam int NUM_SRC = 32;
    localparam int DATA_W  = 32;

    localparam logic [6:0] A_EN = 7'h00, A_ROUTE = 7'h04, A_POL = 7'h08, A_TRIG = 7'h0C,
                           A_CLR = 7'h10, A_VCTRL = 7'h14, A_GMASK = 7'h18, A_VECT = 7'h1C;
    localparam logic [31:0] VEC_NONE = 32'h8000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_i = '0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [6:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o, fiq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    vpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic clean();
        src_i = '0;
        bus_write(A_EN, 32'h0);
        bus_write(A_ROUTE, 32'h0);
        bus_write(A_TRIG, 32'h0);
        bus_write(A_POL, 32'h0);
        bus_write(A_VCTRL, 32'h0);
        tick(2);
        bus_write(A_CLR, 32'hFFFF_FFFF);
        bus_write(A_GMASK, 32'h3);
        tick(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_o", 32'(irq_o), 0);
        check("R1 fiq_o", 32'(fiq_o), 0);
        bus_read(A_VECT, d);  check("R1 vector", d, VEC_NONE);
        bus_read(7'h20, d);   check("R1 prio word0", d, 32'h0302_0100);
        bus_read(A_EN, d);    check("R1 enable", d, 0);
        bus_read(A_GMASK, d); check("R1 gmask", d, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        bus_write(A_EN, 32'h40); bus_write(A_ROUTE, 32'h40);
        src_i[6] = 1'b1; tick(1); src_i[6] = 1'b0; tick(2);
        check("R3 irq held after pulse", 32'(irq_o), 1);
        bus_read(A_CLR, d); check("R3 pending bit6", d, 32'h40);
        bus_write(A_CLR, 32'h40); tick(1);
        check("R3 cleared by W1C", 32'(irq_o), 0);
        clean();
    endtask

    task automatic t_level();
        bus_write(A_TRIG, 32'h200); bus_write(A_EN, 32'h200); bus_write(A_ROUTE, 32'h200);
        src_i[9] = 1'b1; tick(1);
        check("R4 level active", 32'(irq_o), 1);
        bus_write(A_CLR, 32'h200); tick(1);
        check("R4 clear ignored", 32'(irq_o), 1);
        src_i[9] = 1'b0; tick(1);
        check("R4 level drops", 32'(irq_o), 0);
        clean();
    endtask

    task automatic t_polarity();
        src_i[3] = 1'b1;
        bus_write(A_POL, 32'h8); bus_write(A_TRIG, 32'h8);
        bus_write(A_EN, 32'h8); bus_write(A_ROUTE, 32'h8); tick(1);
        check("R2 active-low input high", 32'(irq_o), 0);
        src_i[3] = 1'b0; tick(1);
        check("R2 active-low input low", 32'(irq_o), 1);
        clean();
    endtask

    task automatic t_route_mask();
        bus_write(A_EN, 32'h1000);
        src_i[12] = 1'b1; tick(1); src_i[12] = 1'b0; tick(1);
        check("R5 fiq routed", 32'(fiq_o), 1);
        check("R5 irq not routed", 32'(irq_o), 0);
        bus_write(A_GMASK, 32'h2); tick(1);
        check("R7 fiq masked", 32'(fiq_o), 0);
        bus_write(A_ROUTE, 32'h1000); bus_write(A_GMASK, 32'h1); tick(1);
        check("R7 irq masked", 32'(irq_o), 0);
        bus_write(A_GMASK, 32'h3); tick(1);
        check("R5 irq routed", 32'(irq_o), 1);
        clean();
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(A_ROUTE, 32'h0010_0000);
        src_i[20] = 1'b1; tick(1); src_i[20] = 1'b0; tick(2);
        check("R6 disabled irq low", 32'(irq_o), 0);
        bus_read(A_VECT, d); check("R6 disabled no vector", d, VEC_NONE);
        bus_read(A_CLR, d);  check("R6 pending still latched", d, 32'h0010_0000);
        bus_write(A_EN, 32'h0010_0000); tick(1);
        check("R6 enabled irq high", 32'(irq_o), 1);
        clean();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        bus_write(A_TRIG, 32'h0002_0020); bus_write(A_EN, 32'h0002_0020);
        bus_write(A_ROUTE, 32'h0002_0020);
        src_i[5] = 1'b1; src_i[17] = 1'b1; tick(2);
        bus_read(A_VECT, d); check("R8 default priority winner", d, 32'd5);
        bus_write(7'h30, 32'hF3F2_01F0);
        bus_read(7'h30, d); check("R12 word 0x30 layout", d, 32'h1312_0110);
        tick(1);
        bus_read(A_VECT, d); check("R8 lower value wins", d, 32'd17);
        bus_write(7'h24, 32'h0706_0104); tick(1);
        bus_read(A_VECT, d); check("R8 tie lower index", d, 32'd5);
        bus_write(7'h24, 32'h0706_0504); bus_write(7'h30, 32'h1312_1110);
        clean();
    endtask

    task automatic t_ack();
        logic [31:0] d;
        bus_write(A_EN, 32'h0200_0000); bus_write(A_ROUTE, 32'h0200_0000);
        src_i[25] = 1'b1; tick(1); src_i[25] = 1'b0; tick(2);
        bus_read(A_VECT, d); check("R9 vector index 25", d, 32'd25);
        bus_read(A_VECT, d); check("R11 read without ack keeps", d, 32'd25);
        bus_write(A_VCTRL, 32'h8000_0000);
        bus_read(A_VECT, d); check("R10 acking read returns 25", d, 32'd25);
        bus_read(A_CLR, d);  check("R10 pending cleared", d, 0);
        check("R10 irq dropped", 32'(irq_o), 0);
        bus_read(A_VECT, d); check("R9 vector invalid after ack", d, VEC_NONE);
        clean();
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        bus_write(A_GMASK, 32'h3);
        t_edge();
        t_level();
        t_polarity();
        t_route_mask();
        t_enable();
        t_prio();
        t_ack();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule